// File: doc/BRIEF.md
# Sparse-Wired Lookup Table Layer

This block evaluates a layer of small Boolean lookup tables over a unary (thermometer-coded) feature bus. Every table takes between one and six address bits. Each address bit is wired to one fixed position of the input bus. The wiring comes from a connection map that is fixed when the block is built, and there is no run-time switching. Each table holds a constant truth table, and the table output is the bit that the gathered address selects. The layer has no arithmetic in it, only wiring and table lookups.

The tables are split evenly among the output classes, and the output bus is ordered class by class so that a downstream popcount stage can take one contiguous slice per class. A build-time switch sets whether the outputs go through one register stage or leave the block combinationally.

Top module: `lut_layer_array`

## Requirements
- R1: Output bit l equals bit `a` of the truth table of table l. Table l occupies bits [l*2^K +: 2^K] of the TRUTH parameter.
- R2: Address bit j of table l is the input bus bit whose index is held at bits [(l*K+j)*SEL_W +: SEL_W] of CONN_MAP. Connection 0 supplies the least significant address bit.
- R3: Tables are numbered class by class. Output bits k*P through k*P+P-1 belong to class k, where P = LUTS_PER_CLS, and the layer holds NUM_CLS*P tables.
- R4: With PIPE=1, the outputs show the bus value captured at the previous rising clock edge, one cycle of latency.
- R5: With PIPE=0, the outputs follow the bus combinationally in the same cycle, with no clock involved.
- R6: Bus bits that no connection references have no effect on any output.
- R7: The layer works for any table width K from 1 to 6 and any bus width, shown with K=6 and K=2.
- R8: With PIPE=1, all outputs read 0 while rst_ni is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the optional output stage |
| rst_ni | input | 1 | Active-low asynchronous reset |
| therm_i | input | IN_W | Thermometer-coded feature bus |
| lut_o | output | NUM_CLS*LUTS_PER_CLS | One bit per table, grouped by class |

## Verification
In the registered variant, each bus value is driven on a falling edge and captured at the rising edge that follows. The bench then reads the outputs on the next falling edge, one rising edge after the bus was driven. In the combinational variant, the bench reads the outputs a short delay after driving the bus, with no clock edge in between. The reference model applies the connection map and truth tables to the bus in software, and checks one class slice at a time. Checks on unreferenced bits compare the output before and after the toggle at the same sampling offset.

// File: rtl/lut_layer_pkg.sv
package lut_layer_pkg;
  localparam int unsigned DEF_IN_W  = 48;
  localparam int unsigned DEF_CLS   = 5;
  localparam int unsigned DEF_PER   = 2;
  localparam int unsigned DEF_K     = 6;
  localparam int unsigned DEF_SEL_W = $clog2(DEF_IN_W);
  localparam int unsigned DEF_N     = DEF_CLS * DEF_PER;
  localparam int unsigned DEF_TT_W  = 1 << DEF_K;
  localparam int unsigned DEF_MAP_W = DEF_N * DEF_K * DEF_SEL_W;
  localparam int unsigned DEF_TRU_W = DEF_N * DEF_TT_W;

  // Placeholder wiring for default elaboration; real maps come from training.
  function automatic logic [DEF_MAP_W-1:0] def_map();
    logic [DEF_MAP_W-1:0] r;
    r = '0;
    for (int l = 0; l < int'(DEF_N); l++)
      for (int j = 0; j < int'(DEF_K); j++)
        r[(l*DEF_K+j)*DEF_SEL_W +: DEF_SEL_W] = DEF_SEL_W'((l*5 + j*13 + 1) % DEF_IN_W);
    return r;
  endfunction

  function automatic logic [DEF_TRU_W-1:0] def_truth();
    logic [DEF_TRU_W-1:0] r;
    logic [31:0] s;
    s = 32'h1d87_2b41;
    for (int b = 0; b < int'(DEF_TRU_W); b++) begin
      s ^= s << 13;
      s ^= s >> 17;
      s ^= s << 5;
      r[b] = s[7];
    end
    return r;
  endfunction

  localparam logic [DEF_MAP_W-1:0] DEF_MAP   = def_map();
  localparam logic [DEF_TRU_W-1:0] DEF_TRUTH = def_truth();
endpackage

// File: rtl/lut_cell.sv
module lut_cell #(
  parameter int unsigned IN_W  = 48,
  parameter int unsigned K     = 6,
  parameter int unsigned SEL_W = 6,
  parameter logic [K*SEL_W-1:0]  SELS  = '0,
  parameter logic [(1<<K)-1:0]   TABLE = '0
) (
  input  logic [IN_W-1:0] therm_i,
  output logic            bit_o
);
  logic [K-1:0] addr;

  always_comb begin
    for (int j = 0; j < int'(K); j++)
      addr[j] = therm_i[SELS[j*SEL_W +: SEL_W]];
  end

  assign bit_o = TABLE[addr];
endmodule

// File: rtl/lut_class_bank.sv
module lut_class_bank #(
  parameter int unsigned IN_W  = 48,
  parameter int unsigned PER   = 2,
  parameter int unsigned K     = 6,
  parameter int unsigned SEL_W = 6,
  parameter logic [PER*K*SEL_W-1:0]  SELS   = '0,
  parameter logic [PER*(1<<K)-1:0]   TABLES = '0
) (
  input  logic [IN_W-1:0] therm_i,
  output logic [PER-1:0]  bits_o
);
  localparam int unsigned TT_W  = 1 << K;
  localparam int unsigned SEL_T = K * SEL_W;

  for (genvar m = 0; m < int'(PER); m++) begin : g_lut
    lut_cell #(
      .IN_W (IN_W),
      .K    (K),
      .SEL_W(SEL_W),
      .SELS (SELS[m*SEL_T +: SEL_T]),
      .TABLE(TABLES[m*TT_W +: TT_W])
    ) u_cell (
      .therm_i(therm_i),
      .bit_o  (bits_o[m])
    );
  end
endmodule

// File: rtl/lut_out_stage.sv
module lut_out_stage #(
  parameter int unsigned W    = 10,
  parameter bit          PIPE = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  if (PIPE) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q_o <= '0;
      else         q_o <= d_i;
    end
  end else begin : g_wire
    assign q_o = d_i;
  end
endmodule

// File: rtl/lut_layer_array.sv
module lut_layer_array
  import lut_layer_pkg::*;
#(
  parameter int unsigned IN_W         = DEF_IN_W,
  parameter int unsigned NUM_CLS      = DEF_CLS,
  parameter int unsigned LUTS_PER_CLS = DEF_PER,
  parameter int unsigned LUT_K        = DEF_K,
  parameter int unsigned SEL_W        = $clog2(IN_W),
  parameter bit          PIPE         = 1'b1,
  parameter logic [NUM_CLS*LUTS_PER_CLS*LUT_K*SEL_W-1:0]  CONN_MAP = DEF_MAP,
  parameter logic [NUM_CLS*LUTS_PER_CLS*(1<<LUT_K)-1:0]   TRUTH    = DEF_TRUTH
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic [IN_W-1:0]                 therm_i,
  output logic [NUM_CLS*LUTS_PER_CLS-1:0] lut_o
);
  localparam int unsigned N      = NUM_CLS * LUTS_PER_CLS;
  localparam int unsigned TT_W   = 1 << LUT_K;
  localparam int unsigned MAP_CL = LUTS_PER_CLS * LUT_K * SEL_W;
  localparam int unsigned TRU_CL = LUTS_PER_CLS * TT_W;

  logic [N-1:0] raw;

  for (genvar k = 0; k < int'(NUM_CLS); k++) begin : g_cls
    lut_class_bank #(
      .IN_W  (IN_W),
      .PER   (LUTS_PER_CLS),
      .K     (LUT_K),
      .SEL_W (SEL_W),
      .SELS  (CONN_MAP[k*MAP_CL +: MAP_CL]),
      .TABLES(TRUTH[k*TRU_CL +: TRU_CL])
    ) u_bank (
      .therm_i(therm_i),
      .bits_o (raw[k*LUTS_PER_CLS +: LUTS_PER_CLS])
    );
  end

  lut_out_stage #(.W(N), .PIPE(PIPE)) u_stage (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw),
    .q_o   (lut_o)
  );
endmodule

// File: rtl/lut_layer_array_chk.sv
module lut_layer_array_chk #(
  parameter int unsigned IN_W    = 48,
  parameter int unsigned N       = 10,
  parameter int unsigned LUT_K   = 6,
  parameter int unsigned SEL_W   = 6,
  parameter bit          PIPE    = 1'b1,
  parameter logic [N*LUT_K*SEL_W-1:0] CONN_MAP = '0
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [IN_W-1:0] therm_i,
  input logic [N-1:0]    lut_o
);
  function automatic logic [IN_W-1:0] used_mask();
    logic [IN_W-1:0] m;
    m = '0;
    for (int i = 0; i < int'(N*LUT_K); i++)
      m[CONN_MAP[i*SEL_W +: SEL_W]] = 1'b1;
    return m;
  endfunction

  localparam logic [IN_W-1:0] USED = used_mask();

  logic [1:0] seen;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         seen <= '0;
    else if (seen != 2'd2) seen <= seen + 2'd1;
  end

  if (PIPE) begin : g_pipe
    // R4: a bus held across an edge leaves the registered output unchanged one cycle later
    a_r4_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (seen == 2'd2 && $stable(therm_i)) |=> $stable(lut_o));
    // R6: toggles confined to unreferenced bits do not reach the outputs
    a_r6_unused_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (seen == 2'd2 && ((therm_i ^ $past(therm_i)) & USED) == '0) |=> $stable(lut_o));
    // R8: the output stage is cleared while reset is held
    always @(negedge clk_i) begin
      if (!rst_ni) a_r8_reset_zero: assert (lut_o == '0);
    end
  end else begin : g_comb
    // R5/R6: with no register, equal referenced bits give equal outputs in the same cycle
    a_r5_comb_follow: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (seen != 2'd0 && ((therm_i ^ $past(therm_i)) & USED) == '0) |-> $stable(lut_o));
  end

  // R1: outputs are always driven to known values once out of reset
  a_r1_known: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen == 2'd2) |-> !$isunknown(lut_o));
endmodule

bind lut_layer_array lut_layer_array_chk #(
  .IN_W    (IN_W),
  .N       (NUM_CLS*LUTS_PER_CLS),
  .LUT_K   (LUT_K),
  .SEL_W   (SEL_W),
  .PIPE    (PIPE),
  .CONN_MAP(CONN_MAP)
) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .therm_i(therm_i),
  .lut_o  (lut_o)
);

// File: tb/lut_layer_array_tb.sv
module lut_layer_array_tb;
  localparam int CLK_PERIOD = 10;

  // registered instance, K=6
  localparam int M_IN = 48, M_C = 5, M_P = 2, M_K = 6, M_SEL = 6;
  localparam int M_N = M_C * M_P, M_TW = 1 << M_K;
  // combinational instance, K=2
  localparam int C_IN = 8, C_C = 2, C_P = 3, C_K = 2, C_SEL = 3;
  localparam int C_N = C_C * C_P, C_TW = 1 << C_K;

  function automatic logic [M_N*M_K*M_SEL-1:0] m_map();
    logic [M_N*M_K*M_SEL-1:0] r;
    for (int l = 0; l < M_N; l++)
      for (int j = 0; j < M_K; j++)
        r[(l*M_K+j)*M_SEL +: M_SEL] = M_SEL'((l*11 + j*7) % (M_IN-1));
    return r;
  endfunction

  function automatic logic [M_N*M_TW-1:0] m_tt();
    logic [M_N*M_TW-1:0] r;
    for (int l = 0; l < M_N; l++)
      for (int a = 0; a < M_TW; a++)
        r[l*M_TW+a] = (l == 0) ? a[0] : 1'(((l*73 + a*a*37 + a*19) >> 3) & 1);
    return r;
  endfunction

  function automatic logic [C_N*C_K*C_SEL-1:0] c_map();
    logic [C_N*C_K*C_SEL-1:0] r;
    for (int l = 0; l < C_N; l++)
      for (int j = 0; j < C_K; j++)
        r[(l*C_K+j)*C_SEL +: C_SEL] = C_SEL'((l*3 + j*5) % (C_IN-1));
    return r;
  endfunction

  function automatic logic [C_N*C_TW-1:0] c_tt();
    logic [C_N*C_TW-1:0] r;
    for (int l = 0; l < C_N; l++)
      for (int a = 0; a < C_TW; a++)
        r[l*C_TW+a] = 1'(((l*5 + a*3 + 1) >> 1) & 1);
    return r;
  endfunction

  localparam logic [M_N*M_K*M_SEL-1:0] M_MAP = m_map();
  localparam logic [M_N*M_TW-1:0]      M_TT  = m_tt();
  localparam logic [C_N*C_K*C_SEL-1:0] C_MAP = c_map();
  localparam logic [C_N*C_TW-1:0]      C_TT  = c_tt();

  function automatic logic [M_N-1:0] m_model(logic [M_IN-1:0] b);
    logic [M_N-1:0] o;
    logic [M_K-1:0] a;
    for (int l = 0; l < M_N; l++) begin
      for (int j = 0; j < M_K; j++) a[j] = b[M_MAP[(l*M_K+j)*M_SEL +: M_SEL]];
      o[l] = M_TT[l*M_TW + int'(a)];
    end
    return o;
  endfunction

  function automatic logic [C_N-1:0] c_model(logic [C_IN-1:0] b);
    logic [C_N-1:0] o;
    logic [C_K-1:0] a;
    for (int l = 0; l < C_N; l++) begin
      for (int j = 0; j < C_K; j++) a[j] = b[C_MAP[(l*C_K+j)*C_SEL +: C_SEL]];
      o[l] = C_TT[l*C_TW + int'(a)];
    end
    return o;
  endfunction

  logic clk_i = 1'b0;
  logic rst_ni = 1'b1;
  logic [M_IN-1:0] m_bus = '0;
  logic [C_IN-1:0] c_bus = '0;
  logic [M_N-1:0]  m_out;
  logic [C_N-1:0]  c_out;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  lut_layer_array #(
    .IN_W(M_IN), .NUM_CLS(M_C), .LUTS_PER_CLS(M_P), .LUT_K(M_K), .SEL_W(M_SEL),
    .PIPE(1'b1), .CONN_MAP(M_MAP), .TRUTH(M_TT)
  ) u_dut (.clk_i(clk_i), .rst_ni(rst_ni), .therm_i(m_bus), .lut_o(m_out));

  lut_layer_array #(
    .IN_W(C_IN), .NUM_CLS(C_C), .LUTS_PER_CLS(C_P), .LUT_K(C_K), .SEL_W(C_SEL),
    .PIPE(1'b0), .CONN_MAP(C_MAP), .TRUTH(C_TT)
  ) u_dut_comb (.clk_i(clk_i), .rst_ni(rst_ni), .therm_i(c_bus), .lut_o(c_out));

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [M_IN-1:0] therm_bus();
    logic [M_IN-1:0] b;
    for (int f = 0; f < M_IN/8; f++) begin
      int lvl;
      lvl = int'($urandom_range(8));
      for (int t = 0; t < 8; t++) b[f*8+t] = (t < lvl);
    end
    return b;
  endfunction

  task automatic main_vec(logic [M_IN-1:0] v);
    logic [M_N-1:0] e;
    @(negedge clk_i);
    m_bus = v;
    @(negedge clk_i);
    e = m_model(v);
    // R1 R3: each class slice against the model
    for (int k = 0; k < M_C; k++)
      chk($sformatf("R1/R3 class %0d", k), 64'(m_out[k*M_P +: M_P]), 64'(e[k*M_P +: M_P]));
  endtask

  task automatic comb_vec(logic [C_IN-1:0] v);
    c_bus = v;
    #1;
    chk("R5/R7 comb K=2", 64'(c_out), 64'(c_model(v)));
  endtask

  initial begin
    #(CLK_PERIOD*200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [M_N-1:0] hold;
    logic [M_IN-1:0] v;
    void'($urandom(32'h5eed_0042));
    #1 rst_ni = 1'b0;
    m_bus = '1;
    @(negedge clk_i);
    @(negedge clk_i);
    chk("R8 reset zero", 64'(m_out), 64'd0);
    rst_ni = 1'b1;

    main_vec('0);
    main_vec('1);

    // R2: only connection 0 of table 0 set -> address 1; only connection 5 -> address 32
    v = '0; v[M_MAP[0 +: M_SEL]] = 1'b1;
    main_vec(v);
    chk("R2 conn0 is addr lsb", 64'(m_out[0]), 64'd1);
    v = '0; v[M_MAP[5*M_SEL +: M_SEL]] = 1'b1;
    main_vec(v);
    chk("R2 conn5 is addr msb", 64'(m_out[0]), 64'd0);

    // R4: value appears after exactly one rising edge, not before
    @(negedge clk_i);
    v = therm_bus();
    hold = m_out;
    m_bus = v;
    #1 chk("R4 no change before edge", 64'(m_out), 64'(hold));
    @(negedge clk_i);
    chk("R4 after one edge", 64'(m_out), 64'(m_model(v)));

    for (int i = 0; i < 150; i++) main_vec(therm_bus());
    for (int i = 0; i < 100; i++) main_vec({$urandom, $urandom});

    // R6: bit 47 is never referenced
    for (int i = 0; i < 8; i++) begin
      v = therm_bus();
      main_vec(v);
      hold = m_out;
      v[M_IN-1] = ~v[M_IN-1];
      @(negedge clk_i); m_bus = v;
      @(negedge clk_i);
      chk("R6 unused bit main", 64'(m_out), 64'(hold));
    end

    // combinational instance, exhaustive over the 8-bit bus
    for (int i = 0; i < 256; i++) comb_vec(C_IN'(i));
    // R6: bit 7 of the small bus is never referenced
    for (int i = 0; i < 128; i++) begin
      logic [C_N-1:0] h;
      c_bus = C_IN'(i); #1 h = c_out;
      c_bus = C_IN'(i) | 8'h80; #1;
      chk("R6 unused bit comb", 64'(c_out), 64'(h));
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule